// File: doc/BRIEF.md
# General-Purpose I/O Line Bank Register Block

This block holds the configuration and data registers of a bank of up to 32 general-purpose lines behind a plain 32-bit register bus with word-aligned offsets. Each line is either a general I/O line or an interrupt input. A general line has a direction bit, an output data bit, an output-source choice and an input-enable bit. The block drives the pad output value and the pad output enable for each line. It returns the synchronized pad level, or the driven level, through a read-only input data register.

The per-line interrupt configuration is held here but not acted upon. This covers the mode bit, the polarity, the edge or level choice, the one-edge or both-edge choice and the filter enable. These bits are exported, together with the synchronized pad levels, to a separate interrupt sensing block. Two build options shape the readback. One gates each line's input data with its input-enable bit. The other, a legacy readback option, makes lines driven as outputs report their driven value instead of the pad.

Top module: `gpio_bank_regs`

## Requirements
- R1: A synchronous active-low reset clears every register to 0. All lines then become general-I/O inputs: pad_oe and pad_out are 0, and every register reads 0.
- R2: The read/write registers sit at these byte offsets and read back the value last written:
  - line mode 0x00
  - direction 0x04
  - output data 0x08
  - polarity 0x20
  - edge select 0x24
  - filter enable 0x28
  - output source 0x40
  - both-edge select 0x4C
  - input enable 0x50
- R3: The input data register sits at 0x0C and is read-only. A write to it, or to any unmapped offset, changes no register. A read of an unmapped offset returns 0.
- R4: pad_oe bit n is 1 exactly when line mode bit n is 0 and direction bit n is 1. Mode bit n = 1 makes line n an interrupt input, and its driver stays off.
- R5: pad_out bit n equals output data bit n when output source bit n is 0. When output source bit n is 1, the alternate source drives 0.
- R6: The output data register keeps a value written while a line is an input. That value appears on pad_out and is driven once the line turns to output.
- R7: Pad inputs pass through two flops. A pad change made before edge k shows on pin_sync and in the input data register after edge k+1, and not after edge k.
- R8: With the input gate option on (HAS_INPUT_GATE=1), input data bit n reads 0 unless input enable bit n is 1. With the option off, the input enable register has no effect on readback.
- R9: With LEGACY_READBACK=0, input data always reflects the synchronized pad. With LEGACY_READBACK=1, a line whose pad_oe is 1 reads back its driven pad_out value instead.
- R10: The line mode, polarity, edge select, both-edge select and filter enable registers are exported bit for bit on line_irq_mode, line_pol_neg, line_edge, line_both and line_filt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte offset; bits 1:0 ignored |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the strobe cycle, 0 otherwise |
| pad_in | input | NUM_LINES (32) | Asynchronous pad levels |
| pad_out | output | NUM_LINES (32) | Pad output value |
| pad_oe | output | NUM_LINES (32) | Pad output enable |
| pin_sync | output | NUM_LINES (32) | Synchronized pad levels for interrupt sensing |
| line_irq_mode | output | NUM_LINES (32) | 1 = line is an interrupt input |
| line_pol_neg | output | NUM_LINES (32) | Polarity select per line |
| line_edge | output | NUM_LINES (32) | Edge/level select per line |
| line_both | output | NUM_LINES (32) | Both-edge select per line |
| line_filt | output | NUM_LINES (32) | Filter enable per line |

## Verification
On every cycle, the assertions check several rules:
- The driver never turns on for an interrupt-mode line.
- The alternate output source never drives a 1.
- Gated-off lines read 0.
- Writes land in the addressed register.
- Unmapped or read-only writes disturb nothing.
- Unmapped reads return 0.
- pin_sync lags the pad by exactly two edges.

Only the bench's scenarios can show other behaviour:
- An output value written while a line is an input survives until the line turns to output.
- The legacy build reports driven values for output lines while the default build reports the pad.
- The full offset map reads back as written.

// File: rtl/gpio_bank_pkg.sv
// Package: shared register indices and byte offsets for the GPIO line bank.
// Assumes word-aligned offsets below 0x100.
package gpio_bank_pkg;

    // Number of read/write configuration registers.
    localparam int unsigned NUM_RW = 9;

    // Index of each read/write register in the register store.
    localparam int unsigned IDX_MODE = 0;
    localparam int unsigned IDX_DIR  = 1;
    localparam int unsigned IDX_OUTD = 2;
    localparam int unsigned IDX_POL  = 3;
    localparam int unsigned IDX_EDGE = 4;
    localparam int unsigned IDX_FILT = 5;
    localparam int unsigned IDX_SRC  = 6;
    localparam int unsigned IDX_BOTH = 7;
    localparam int unsigned IDX_INEN = 8;

    // Byte offset of the read-only input data register.
    localparam logic [7:0] OFS_INDATA = 8'h0C;

    // Byte offset of read/write register idx.
    function automatic logic [7:0] rw_offset(input int unsigned idx);
        case (idx)
            IDX_MODE: rw_offset = 8'h00;
            IDX_DIR:  rw_offset = 8'h04;
            IDX_OUTD: rw_offset = 8'h08;
            IDX_POL:  rw_offset = 8'h20;
            IDX_EDGE: rw_offset = 8'h24;
            IDX_FILT: rw_offset = 8'h28;
            IDX_SRC:  rw_offset = 8'h40;
            IDX_BOTH: rw_offset = 8'h4C;
            default:  rw_offset = 8'h50;
        endcase
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
// Module: gpio_pin_sync
// Brings asynchronous pad levels into the clock domain through a chain of
// STAGES flops per line. Assumes each pad bit is sampled independently;
// multi-bit coherence is not provided.
module gpio_pin_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    // Shift the pad levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= pad_in;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];

    // Cycles since reset release, saturating; used only by the checker.
    logic [1:0] age_q;

    // Count cycles since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_chk2
            // R7: output follows the pad exactly two edges later.
            a_r7_two_edge_lag: assert property (@(posedge clk) disable iff (!rst_n)
                (age_q >= 2'd2) |-> (sync_out == $past(pad_in, 2)));
        end
    endgenerate

endmodule

// File: rtl/gpio_cfg_regs.sv
// Module: gpio_cfg_regs
// Register file of the bank. It holds the nine read/write per-line
// registers, decodes word offsets, and returns read data, including the
// read-only input data view supplied by the line path. Assumes one access
// per strobe cycle; address bits 1:0 are ignored.
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] indata_view,
    output logic [NUM_LINES-1:0] reg_mode,
    output logic [NUM_LINES-1:0] reg_dir,
    output logic [NUM_LINES-1:0] reg_outd,
    output logic [NUM_LINES-1:0] reg_pol,
    output logic [NUM_LINES-1:0] reg_edge,
    output logic [NUM_LINES-1:0] reg_filt,
    output logic [NUM_LINES-1:0] reg_src,
    output logic [NUM_LINES-1:0] reg_both,
    output logic [NUM_LINES-1:0] reg_inen
);

    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0]    word_idx;
    logic [NUM_LINES-1:0] store_q [NUM_RW];
    logic [NUM_RW-1:0]    rw_hit;
    logic                 in_hit;
    logic                 do_wr;
    logic                 do_rd;
    logic                 any_hit;
    logic [1:0]           unused_addr_lsb;

    assign word_idx        = bus_addr[ADDR_W-1:2];
    assign unused_addr_lsb = bus_addr[1:0];
    assign do_wr           = bus_sel && bus_wr;
    assign do_rd           = bus_sel && !bus_wr;
    assign in_hit          = (word_idx == WIDX_W'(OFS_INDATA >> 2));
    assign any_hit         = (|rw_hit) || in_hit;

    generate
        for (genvar i = 0; i < NUM_RW; i++) begin : g_reg
            localparam logic [7:0] OFS = rw_offset(i);

            // Offset match for this register.
            assign rw_hit[i] = (word_idx == WIDX_W'(OFS >> 2));

            // Hold this register; load it on an addressed write.
            always_ff @(posedge clk) begin
                if (!rst_n)                   store_q[i] <= '0;
                else if (do_wr && rw_hit[i])  store_q[i] <= bus_wdata[NUM_LINES-1:0];
            end

            // R2: an addressed write lands in this register on the next cycle.
            a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
                (do_wr && rw_hit[i]) |=> (store_q[i] == $past(bus_wdata[NUM_LINES-1:0])));

            // R3: a write to another offset leaves this register alone.
            a_r3_other_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
                (do_wr && !rw_hit[i]) |=> $stable(store_q[i]));
        end
    endgenerate

    // Read data mux: zero-extended register or input view, 0 otherwise.
    always_comb begin
        bus_rdata = '0;
        if (do_rd) begin
            if (in_hit) bus_rdata = DATA_W'(indata_view);
            for (int i = 0; i < NUM_RW; i++) begin
                if (rw_hit[i]) bus_rdata = DATA_W'(store_q[i]);
            end
        end
    end

    assign reg_mode = store_q[IDX_MODE];
    assign reg_dir  = store_q[IDX_DIR];
    assign reg_outd = store_q[IDX_OUTD];
    assign reg_pol  = store_q[IDX_POL];
    assign reg_edge = store_q[IDX_EDGE];
    assign reg_filt = store_q[IDX_FILT];
    assign reg_src  = store_q[IDX_SRC];
    assign reg_both = store_q[IDX_BOTH];
    assign reg_inen = store_q[IDX_INEN];

    // R3: an unmapped read returns 0.
    a_r3_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && !any_hit) |-> (bus_rdata == '0));

    // R1: reset leaves every register cleared.
    a_r1_reset_clears: assert property (@(posedge clk)
        (!rst_n) |=> ((reg_mode | reg_dir | reg_outd | reg_src | reg_inen) == '0));

endmodule

// File: rtl/gpio_line_path.sv
// Module: gpio_line_path
// Per-line datapath: it forms the pad output value and output enable from
// the configuration, and builds the input data view from the synchronized
// pad. HAS_INPUT_GATE gates the view with input enable. LEGACY_READBACK
// shows the driven value for output lines. Assumes registered inputs.
module gpio_line_path #(
    parameter int unsigned NUM_LINES       = 32,
    parameter bit          HAS_INPUT_GATE  = 1'b1,
    parameter bit          LEGACY_READBACK = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] reg_mode,
    input  logic [NUM_LINES-1:0] reg_dir,
    input  logic [NUM_LINES-1:0] reg_outd,
    input  logic [NUM_LINES-1:0] reg_src,
    input  logic [NUM_LINES-1:0] reg_inen,
    input  logic [NUM_LINES-1:0] pin_sync,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic [NUM_LINES-1:0] indata_view
);

    generate
        for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
            logic drive_en;
            logic level_seen;
            logic gate_ok;

            // Driver on only for a general line set to output.
            assign drive_en   = !reg_mode[n] && reg_dir[n];
            assign pad_oe[n]  = drive_en;
            // Output register when selected, alternate source (0) otherwise.
            assign pad_out[n] = reg_src[n] ? 1'b0 : reg_outd[n];

            if (LEGACY_READBACK) begin : g_legacy
                assign level_seen = drive_en ? pad_out[n] : pin_sync[n];
            end else begin : g_pad
                assign level_seen = pin_sync[n];
            end

            if (HAS_INPUT_GATE) begin : g_gate
                assign gate_ok = reg_inen[n];
            end else begin : g_nogate
                logic unused_inen;
                assign unused_inen = reg_inen[n];
                assign gate_ok     = 1'b1;
            end

            assign indata_view[n] = level_seen && gate_ok;
        end
    endgenerate

    // R4: an interrupt-mode line never has its driver on.
    a_r4_irq_line_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & reg_mode) == '0));

    // R5: the alternate source never drives a 1.
    a_r5_alt_source_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & reg_src) == '0));

    // R8: gated-off lines read 0 when the gate option is built in.
    a_r8_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_INPUT_GATE == 1'b1) |-> ((indata_view & ~reg_inen) == '0));

endmodule

// File: rtl/gpio_bank_regs.sv
// Module: gpio_bank_regs (top)
// GPIO line bank: register file, pad synchronizer and per-line datapath.
// It exports the interrupt configuration and the synchronized pads to an
// external interrupt sensing block. Assumes NUM_LINES <= DATA_W and
// ADDR_W >= 7.
module gpio_bank_regs #(
    parameter int unsigned NUM_LINES       = 32,
    parameter int unsigned DATA_W          = 32,
    parameter int unsigned ADDR_W          = 8,
    parameter int unsigned SYNC_STAGES     = 2,
    parameter bit          HAS_INPUT_GATE  = 1'b1,
    parameter bit          LEGACY_READBACK = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic [NUM_LINES-1:0] pin_sync,
    output logic [NUM_LINES-1:0] line_irq_mode,
    output logic [NUM_LINES-1:0] line_pol_neg,
    output logic [NUM_LINES-1:0] line_edge,
    output logic [NUM_LINES-1:0] line_both,
    output logic [NUM_LINES-1:0] line_filt
);

    logic [NUM_LINES-1:0] reg_mode, reg_dir, reg_outd, reg_src, reg_inen;
    logic [NUM_LINES-1:0] indata_view;

    gpio_cfg_regs #(
        .NUM_LINES (NUM_LINES),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .indata_view (indata_view),
        .reg_mode    (reg_mode),
        .reg_dir     (reg_dir),
        .reg_outd    (reg_outd),
        .reg_pol     (line_pol_neg),
        .reg_edge    (line_edge),
        .reg_filt    (line_filt),
        .reg_src     (reg_src),
        .reg_both    (line_both),
        .reg_inen    (reg_inen)
    );

    gpio_pin_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .sync_out (pin_sync)
    );

    gpio_line_path #(
        .NUM_LINES       (NUM_LINES),
        .HAS_INPUT_GATE  (HAS_INPUT_GATE),
        .LEGACY_READBACK (LEGACY_READBACK)
    ) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_mode    (reg_mode),
        .reg_dir     (reg_dir),
        .reg_outd    (reg_outd),
        .reg_src     (reg_src),
        .reg_inen    (reg_inen),
        .pin_sync    (pin_sync),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .indata_view (indata_view)
    );

    assign line_irq_mode = reg_mode;

    // R4: a direction write turns on exactly the general lines it names.
    a_r4_dir_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1)))
        |=> (pad_oe == ($past(bus_wdata[NUM_LINES-1:0]) & ~line_irq_mode)));

endmodule

// File: tb/gpio_bank_regs_test.sv
// Bench: directed scenarios, one task each, on a default build (uut) and a
// legacy-readback build without input gate (uut_lg) sharing bus and pads.
module gpio_bank_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pad_in = '0;
    logic [31:0] rdata, pad_out, pad_oe, pin_sync;
    logic [31:0] irq_mode, pol_neg, edge_sel, both_sel, filt_en;
    logic [31:0] lg_rdata, lg_pad_out, lg_pad_oe, lg_pin_sync;
    logic [31:0] lg_irq_mode, lg_pol, lg_edge, lg_both, lg_filt;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    gpio_bank_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_sync(pin_sync),
        .line_irq_mode(irq_mode), .line_pol_neg(pol_neg), .line_edge(edge_sel),
        .line_both(both_sel), .line_filt(filt_en)
    );

    gpio_bank_regs #(.HAS_INPUT_GATE(1'b0), .LEGACY_READBACK(1'b1)) uut_lg (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(lg_rdata),
        .pad_in(pad_in), .pad_out(lg_pad_out), .pad_oe(lg_pad_oe),
        .pin_sync(lg_pin_sync), .line_irq_mode(lg_irq_mode), .line_pol_neg(lg_pol),
        .line_edge(lg_edge), .line_both(lg_both), .line_filt(lg_filt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] dl);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = rdata; dl = lg_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic clear_all();
        foreach (offs_all[i]) wr(offs_all[i], 32'h0);
    endtask

    logic [7:0] offs_all [9] = '{8'h00, 8'h04, 8'h08, 8'h20, 8'h24, 8'h28, 8'h40, 8'h4C, 8'h50};

    // R1: reset state.
    task automatic t_reset();
        logic [31:0] d, dl;
        check("R1 pad_oe after reset", pad_oe, 32'h0);
        check("R1 pad_out after reset", pad_out, 32'h0);
        foreach (offs_all[i]) begin
            rd(offs_all[i], d, dl);
            check("R1 register reads 0 after reset", d, 32'h0);
        end
    endtask

    // R2 and R3: offset map readback, unmapped and read-only offsets.
    task automatic t_regmap();
        logic [31:0] d, dl;
        foreach (offs_all[i]) wr(offs_all[i], 32'h1111_0000 * (i + 1) + 32'h0000_00A0 + i);
        foreach (offs_all[i]) begin
            rd(offs_all[i], d, dl);
            check("R2 readback at offset", d, 32'h1111_0000 * (i + 1) + 32'h0000_00A0 + i);
        end
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h30, d, dl);
        check("R3 unmapped read is 0", d, 32'h0);
        foreach (offs_all[i]) begin
            rd(offs_all[i], d, dl);
            check("R3 register unchanged by unmapped/read-only write", d,
                  32'h1111_0000 * (i + 1) + 32'h0000_00A0 + i);
        end
        clear_all();
    endtask

    // R4: output enable only on general lines set to output.
    task automatic t_oe();
        wr(8'h00, 32'h0000_00F0);
        wr(8'h04, 32'h0000_00FF);
        #1 check("R4 pad_oe masked by interrupt mode", pad_oe, 32'h0000_000F);
        clear_all();
    endtask

    // R5: output source select.
    task automatic t_src();
        wr(8'h08, 32'hA5A5_A5A5);
        wr(8'h40, 32'h0000_FFFF);
        #1 check("R5 alternate source drives 0", pad_out, 32'hA5A5_0000);
        wr(8'h40, 32'h0);
        #1 check("R5 output register drives pad_out", pad_out, 32'hA5A5_A5A5);
        clear_all();
    endtask

    // R6: output data written while input is kept and driven later.
    task automatic t_hold();
        wr(8'h08, 32'h1234_5678);
        #1 check("R6 no drive while input", pad_oe, 32'h0);
        wr(8'h04, 32'hFFFF_FFFF);
        #1 check("R6 driver on after direction change", pad_oe, 32'hFFFF_FFFF);
        check("R6 held value driven", pad_out, 32'h1234_5678);
        clear_all();
    endtask

    // R7: two-edge input synchronizer.
    task automatic t_sync();
        logic [31:0] d, dl;
        wr(8'h50, 32'hFFFF_FFFF);
        @(negedge clk);
        pad_in = 32'h5A5A_C3C3;
        @(posedge clk);
        rd(8'h0C, d, dl);
        check("R7 not visible after one edge", d, 32'h0);
        check("R7 pin_sync not after one edge", pin_sync, 32'h0);
        rd(8'h0C, d, dl);
        check("R7 visible after two edges", d, 32'h5A5A_C3C3);
        check("R7 pin_sync after two edges", pin_sync, 32'h5A5A_C3C3);
        @(negedge clk);
        pad_in = 32'h0;
        clear_all();
    endtask

    // R8: input gate per line, and no gate in the other build.
    task automatic t_gate();
        logic [31:0] d, dl;
        wr(8'h50, 32'h0000_FFFF);
        @(negedge clk);
        pad_in = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rd(8'h0C, d, dl);
        check("R8 gated lines read 0", d, 32'h0000_FFFF);
        check("R8 no gate option ignores input enable", dl, 32'hFFFF_FFFF);
        @(negedge clk);
        pad_in = 32'h0;
        repeat (3) @(negedge clk);
        clear_all();
    endtask

    // R9: legacy readback of driven value versus pad.
    task automatic t_legacy();
        logic [31:0] d, dl;
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'h08, 32'h0000_000F);
        wr(8'h04, 32'h0000_00FF);
        @(negedge clk);
        pad_in = 32'h0000_01F0;
        repeat (3) @(negedge clk);
        rd(8'h0C, d, dl);
        check("R9 default build reads pad", d, 32'h0000_01F0);
        check("R9 legacy build reads driven value on outputs", dl, 32'h0000_010F);
        @(negedge clk);
        pad_in = 32'h0;
        repeat (3) @(negedge clk);
        clear_all();
    endtask

    // R10: interrupt configuration exported.
    task automatic t_export();
        wr(8'h00, 32'h8000_0001);
        wr(8'h20, 32'h0F0F_0000);
        wr(8'h24, 32'h00F0_00F0);
        wr(8'h4C, 32'h3000_0003);
        wr(8'h28, 32'hC000_000C);
        #1;
        check("R10 mode exported", irq_mode, 32'h8000_0001);
        check("R10 polarity exported", pol_neg, 32'h0F0F_0000);
        check("R10 edge select exported", edge_sel, 32'h00F0_00F0);
        check("R10 both-edge exported", both_sel, 32'h3000_0003);
        check("R10 filter enable exported", filt_en, 32'hC000_000C);
        clear_all();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_oe();
        t_src();
        t_hold();
        t_sync();
        t_gate();
        t_legacy();
        t_export();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule